// File: doc/BRIEF.md
# Ring Network Receive Page Writer

This block sits between a byte-stream receiver and a paged packet RAM. Each incoming frame carries a source identifier, a destination identifier, one or two length bytes, and then a payload. The block stores every byte in the RAM page that the host selected with its last "arm receive" command. The stored layout is the same as the sender's buffer layout, so a received frame can be sent again after only its two identifier bytes are rewritten. The length bytes count back from the end of the page, so the payload always ends on the last byte of a 256-byte region. A zero in the first length byte marks a long frame. For a long frame, the second length byte counts back from the end of a 512-byte page.

A handshake flag, the receive-full bit, rises once a complete, well-formed frame has been stored. While the flag is set, the block refuses further frames so that the stored page cannot be overwritten. The host reads the flag from the status port or takes an interrupt through a mask register. It then re-arms reception with a new page number. Frames with a bad length encoding, a wrong byte count, or a long encoding while long frames are disabled are abandoned without raising the flag.

The byte input is valid/ready. A byte transfers on a rising edge where `s_valid` and `s_ready` are both high, and `s_last` marks the final byte of a frame. The block never applies back-pressure. `s_ready` is low only during reset and the first edge that releases it. Every accepted byte, including a byte that is discarded, is consumed in its own cycle.

Top module: `rxbuf_ctrl`

## Requirements
- R1: The first frame byte is written to page offset 0 and the second to offset 1. The RAM address is page*512+offset when long frames are enabled and page*256+offset otherwise.
- R2: When the third byte L is between 3 and 255, the frame is short. L is stored at offset 2, and the frame carries N = 256-L payload bytes, with payload byte k written to offset L+k.
- R3: When the third byte is 0 and long frames are enabled, the fourth byte M (valid range 4 to 255) is stored at offset 3. The frame carries N = 512-M payload bytes, with payload byte k written to offset M+k.
- R4: Status bit 0 (receive-full) becomes 1 on the edge that stores the final payload byte, which must be the byte flagged with `s_last`. If `s_last` arrives early or late, the frame is abandoned and the bit stays 0.
- R5: Command code 2'b01 (arm receive) clears status bit 0 and loads the page number from `cmd_arg`. The page number and the long-frame setting are sampled when a frame's first byte is accepted.
- R6: While status bit 0 is 1, every byte of an incoming frame is accepted and discarded, and no RAM write occurs.
- R7: A third byte of 1 or 2, a fourth byte below 4, or a zero third byte while long frames are disabled abandons the frame without setting status bit 0. The rest of that frame is discarded, and the next frame is received normally.
- R8: `irq` is the OR of the bitwise AND of `status` and the 2-bit mask register, which `mask_we` loads from `mask_data`.
- R9: Synchronous reset sets `status` to 2'b10 (bit 1 is the power-on flag), and clears the page, the long-frame setting and the mask. Command code 2'b10 (configure) loads the long-frame enable from `cmd_arg[0]` and clears the power-on flag.
- R10: After reset, `s_ready` stays high, and every RAM write coincides with an accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Received byte valid |
| s_ready | output | 1 | Byte accepted when high with s_valid |
| s_data | input | 8 | Received byte |
| s_last | input | 1 | Final byte of the frame |
| cmd_we | input | 1 | Command write strobe |
| cmd_op | input | 2 | Command code: 01 arm receive, 10 configure |
| cmd_arg | input | PAGE_W | Page number, or bit 0 long-frame enable |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_data | input | 2 | New interrupt mask |
| status | output | 2 | Bit 1 power-on, bit 0 receive-full |
| irq | output | 1 | Interrupt request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | PAGE_W+9 | RAM write address |
| mem_wdata | output | 8 | RAM write data |

## Verification
The bench targets the length extremes: a single-byte short frame, a 253-byte short frame, and long frames of 257 and 508 bytes. An off-by-one in the count-back arithmetic would shift the payload across the page boundary or leave the final byte unwritten. It sends a second frame while the receive-full flag is set and compares the whole RAM against a snapshot, which catches a controller that overwrites the stored page. It also sends frames whose length byte is too small, long frames with long reception disabled, and frames whose end marker comes one byte early or one byte late. A controller that misses any of these would raise receive-full on a broken frame, or lose track of the next frame's header.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef enum logic [2:0] {
    ST_SID, ST_DID, ST_LEN, ST_LEN2, ST_PAY, ST_DROP
  } rx_state_e;

  typedef enum logic [1:0] {
    LEN_OK, LEN_LONG, LEN_BAD
  } len_kind_e;

  localparam logic [1:0] CMD_ARM    = 2'b01;
  localparam logic [1:0] CMD_CONFIG = 2'b10;

  localparam int OFF_W    = 9;
  localparam int STAT_W   = 2;
  localparam int SHORT_LO = 3;
  localparam int LONG_LO  = 4;
endpackage

// File: rtl/rxbuf_len_decode.sv
module rxbuf_len_decode
  import rxbuf_pkg::*;
(
  input  logic [7:0]       len_byte,
  input  logic             second,
  input  logic             long_en,
  output len_kind_e        kind,
  output logic [OFF_W-1:0] start_off,
  output logic [OFF_W-1:0] count
);
  logic [OFF_W:0] span;

  always_comb begin
    start_off = {1'b0, len_byte};
    span      = (second ? 10'd512 : 10'd256) - {2'b00, len_byte};
    count     = span[OFF_W-1:0];
    if (second) begin
      kind = (len_byte < 8'(LONG_LO)) ? LEN_BAD : LEN_OK;
    end else if (len_byte == 8'd0) begin
      kind = long_en ? LEN_LONG : LEN_BAD;
    end else begin
      kind = (len_byte < 8'(SHORT_LO)) ? LEN_BAD : LEN_OK;
    end
  end
endmodule

// File: rtl/rxbuf_addr_gen.sv
module rxbuf_addr_gen
  import rxbuf_pkg::*;
#(
  parameter int PAGE_W = 2,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic [PAGE_W-1:0] page,
  input  logic              long_pg,
  input  logic [OFF_W-1:0]  off,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    if (long_pg) addr = {page, off};
    else         addr = {1'b0, page, off[7:0]};
  end
endmodule

// File: rtl/rxbuf_status.sv
module rxbuf_status
  import rxbuf_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_arg,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_data,
  input  logic              frame_done,
  output logic [STAT_W-1:0] status,
  output logic [PAGE_W-1:0] page,
  output logic              long_en,
  output logic              irq
);
  logic              full_q;
  logic              por_q;
  logic [STAT_W-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= 1'b0;
      por_q   <= 1'b1;
      page    <= '0;
      long_en <= 1'b0;
      mask_q  <= '0;
    end else begin
      if (mask_we) mask_q <= mask_data;
      if (cmd_we && cmd_op == CMD_ARM) begin
        full_q <= 1'b0;
        page   <= cmd_arg;
      end
      if (cmd_we && cmd_op == CMD_CONFIG) begin
        long_en <= cmd_arg[0];
        por_q   <= 1'b0;
      end
      if (frame_done) full_q <= 1'b1;
    end
  end

  assign status = {por_q, full_q};
  assign irq    = |(status & mask_q);
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import rxbuf_pkg::*;
#(
  parameter int PAGE_W = 2,
  localparam int ADDR_W = PAGE_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  input  logic              s_last,
  input  logic              cmd_we,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_arg,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_data,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  rx_state_e         state_q, state_d;
  logic              rdy_q;
  logic [PAGE_W-1:0] cur_page_q, reg_page, use_page;
  logic              cur_long_q, reg_long, use_long;
  logic [OFF_W-1:0]  off_q, off_d, rem_q, rem_d, wr_off;
  logic [OFF_W-1:0]  dec_start, dec_count;
  len_kind_e         dec_kind;
  logic              acc, capture, wr_en, done;

  assign acc     = s_valid && s_ready;
  assign s_ready = rdy_q;

  rxbuf_status #(.PAGE_W(PAGE_W)) u_status (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .mask_we(mask_we), .mask_data(mask_data), .frame_done(done),
    .status(status), .page(reg_page), .long_en(reg_long), .irq(irq)
  );

  rxbuf_len_decode u_dec (
    .len_byte(s_data), .second(state_q == ST_LEN2), .long_en(cur_long_q),
    .kind(dec_kind), .start_off(dec_start), .count(dec_count)
  );

  assign use_page = (state_q == ST_SID) ? reg_page : cur_page_q;
  assign use_long = (state_q == ST_SID) ? reg_long : cur_long_q;

  rxbuf_addr_gen #(.PAGE_W(PAGE_W)) u_addr (
    .page(use_page), .long_pg(use_long), .off(wr_off), .addr(mem_addr)
  );

  always_comb begin
    state_d = state_q;
    off_d   = off_q;
    rem_d   = rem_q;
    wr_en   = 1'b0;
    wr_off  = '0;
    capture = 1'b0;
    done    = 1'b0;
    if (acc) begin
      unique case (state_q)
        ST_SID: begin
          if (status[0]) begin
            state_d = s_last ? ST_SID : ST_DROP;
          end else begin
            wr_en   = 1'b1;
            capture = 1'b1;
            state_d = s_last ? ST_SID : ST_DID;
          end
        end
        ST_DID: begin
          wr_en   = 1'b1;
          wr_off  = 9'd1;
          state_d = s_last ? ST_SID : ST_LEN;
        end
        ST_LEN, ST_LEN2: begin
          wr_en  = 1'b1;
          wr_off = (state_q == ST_LEN) ? 9'd2 : 9'd3;
          if (dec_kind == LEN_BAD) begin
            state_d = s_last ? ST_SID : ST_DROP;
          end else if (dec_kind == LEN_LONG) begin
            state_d = s_last ? ST_SID : ST_LEN2;
          end else begin
            off_d   = dec_start;
            rem_d   = dec_count;
            state_d = s_last ? ST_SID : ST_PAY;
          end
        end
        ST_PAY: begin
          wr_en  = 1'b1;
          wr_off = off_q;
          off_d  = off_q + 9'd1;
          rem_d  = rem_q - 9'd1;
          if (rem_q == 9'd1) begin
            done    = s_last;
            state_d = s_last ? ST_SID : ST_DROP;
          end else if (s_last) begin
            state_d = ST_SID;
          end
        end
        default: begin
          if (s_last) state_d = ST_SID;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_SID;
      rdy_q      <= 1'b0;
      cur_page_q <= '0;
      cur_long_q <= 1'b0;
      off_q      <= '0;
      rem_q      <= '0;
    end else begin
      state_q <= state_d;
      rdy_q   <= 1'b1;
      off_q   <= off_d;
      rem_q   <= rem_d;
      if (capture) begin
        cur_page_q <= reg_page;
        cur_long_q <= reg_long;
      end
    end
  end

  assign mem_we    = wr_en;
  assign mem_wdata = s_data;
endmodule

// File: rtl/rxbuf_ctrl_chk.sv
module rxbuf_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       s_valid,
  input logic       s_ready,
  input logic       s_last,
  input logic       cmd_we,
  input logic [1:0] cmd_op,
  input logic [1:0] status,
  input logic       irq,
  input logic       mem_we
);
  p_full_after_store_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(status[0]) |-> ($past(mem_we) && $past(s_last)));

  p_arm_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_op == 2'b01 && !mem_we) |=> !status[0]);

  p_no_write_when_full_r6: assert property (@(posedge clk) disable iff (rst)
    status[0] |-> !mem_we);

  p_irq_has_source_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != 2'b00));

  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (status == 2'b10));

  p_config_clears_por_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd_op == 2'b10) |=> !status[1]);

  p_write_on_accept_r10: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (s_valid && s_ready));
endmodule

bind rxbuf_ctrl rxbuf_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
  .cmd_we(cmd_we), .cmd_op(cmd_op), .status(status), .irq(irq), .mem_we(mem_we)
);

// File: tb/rxbuf_ctrl_test.sv
module rxbuf_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W = 2;
  localparam int ADDR_W = PAGE_W + 9;
  localparam int MEM_SZ = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0, s_ready, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic cmd_we = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [PAGE_W-1:0] cmd_arg = '0;
  logic mask_we = 1'b0;
  logic [1:0] mask_data = '0;
  logic [1:0] status;
  logic irq, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata;

  logic [7:0] ram  [0:MEM_SZ-1];
  logic [7:0] snap [0:MEM_SZ-1];
  logic [7:0] fb   [0:599];
  int flen;
  int checks = 0, fails = 0, not_ready = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxbuf_ctrl #(.PAGE_W(PAGE_W)) uut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .mask_we(mask_we), .mask_data(mask_data), .status(status), .irq(irq),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_addr(int page, bit lcfg, int off);
    return lcfg ? page * 512 + off : page * 256 + off;
  endfunction

  task automatic do_cmd(logic [1:0] op, int arg);
    @(negedge clk); cmd_we = 1'b1; cmd_op = op; cmd_arg = PAGE_W'(arg);
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic do_mask(logic [1:0] m);
    @(negedge clk); mask_we = 1'b1; mask_data = m;
    @(negedge clk); mask_we = 1'b0;
  endtask

  task automatic build(bit lng, int n);
    logic [31:0] r;
    int hdr;
    r = $urandom; fb[0] = r[7:0];
    r = $urandom; fb[1] = r[7:0];
    if (lng) begin fb[2] = 8'd0; fb[3] = 8'(512 - n); hdr = 4; end
    else begin fb[2] = 8'(256 - n); hdr = 3; end
    for (int k = 0; k < n; k++) begin r = $urandom; fb[hdr + k] = r[7:0]; end
    flen = hdr + n;
  endtask

  task automatic send(int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      if (!s_ready) not_ready++;
      s_valid = 1'b1; s_data = fb[i]; s_last = (i == cnt - 1);
    end
    @(negedge clk); s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic check_frame(int page, bit lcfg, bit lng, int n, string req);
    int bad = 0;
    int hdr = lng ? 4 : 3;
    int start = lng ? 512 - n : 256 - n;
    for (int i = 0; i < hdr; i++)
      if (ram[exp_addr(page, lcfg, i)] !== fb[i]) bad++;
    for (int k = 0; k < n; k++)
      if (ram[exp_addr(page, lcfg, start + k)] !== fb[hdr + k]) bad++;
    chk(bad == 0, req, "mismatched stored bytes", bad, 0);
  endtask

  task automatic take_snap();
    for (int i = 0; i < MEM_SZ; i++) snap[i] = ram[i];
  endtask

  function automatic int snap_diff();
    int d = 0;
    for (int i = 0; i < MEM_SZ; i++) if (ram[i] !== snap[i]) d++;
    return d;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_SZ; i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    chk(status == 2'b10, "R9", "status after reset", int'(status), 2);
    chk(irq == 1'b0, "R9", "irq after reset", int'(irq), 0);
    chk(s_ready == 1'b1, "R10", "ready after reset", int'(s_ready), 1);

    do_mask(2'b10);
    chk(irq == 1'b1, "R8", "irq from power-on flag", int'(irq), 1);
    do_mask(2'b00);
    chk(irq == 1'b0, "R8", "irq masked", int'(irq), 0);

    do_cmd(2'b10, 0);
    chk(status == 2'b00, "R9", "status after configure", int'(status), 0);

    // R1 R2: short frame into page 1
    do_cmd(2'b01, 1);
    build(1'b0, 10); send(flen);
    check_frame(1, 1'b0, 1'b0, 10, "R1 R2 short frame");
    chk(status[0] == 1'b1, "R4", "full after frame", int'(status[0]), 1);
    do_mask(2'b01);
    chk(irq == 1'b1, "R8", "irq on full", int'(irq), 1);
    do_mask(2'b00);
    chk(irq == 1'b0, "R8", "irq masked while full", int'(irq), 0);

    // R6: frame while full must be ignored
    take_snap();
    build(1'b0, 40); send(flen);
    chk(snap_diff() == 0, "R6", "bytes changed while full", snap_diff(), 0);
    chk(status[0] == 1'b1, "R6", "full kept", int'(status[0]), 1);

    do_cmd(2'b01, 2);
    chk(status[0] == 1'b0, "R5", "arm clears full", int'(status[0]), 0);
    build(1'b0, 253); send(flen);
    check_frame(2, 1'b0, 1'b0, 253, "R2 longest short");
    do_cmd(2'b01, 3);
    build(1'b0, 1); send(flen);
    check_frame(3, 1'b0, 1'b0, 1, "R2 single byte payload");
    chk(status[0] == 1'b1, "R4", "full after 1-byte frame", int'(status[0]), 1);

    // R3: long frames
    do_cmd(2'b10, 1);
    do_cmd(2'b01, 1);
    build(1'b1, 300); send(flen);
    check_frame(1, 1'b1, 1'b1, 300, "R3 long frame");
    do_cmd(2'b01, 3);
    build(1'b1, 508); send(flen);
    check_frame(3, 1'b1, 1'b1, 508, "R3 longest long");
    do_cmd(2'b01, 0);
    build(1'b1, 257); send(flen);
    check_frame(0, 1'b1, 1'b1, 257, "R3 shortest long");
    do_cmd(2'b01, 2);
    build(1'b0, 20); send(flen);
    check_frame(2, 1'b1, 1'b0, 20, "R1 R2 short in large page");

    // R7: long frame while long disabled
    do_cmd(2'b10, 0);
    do_cmd(2'b01, 0);
    build(1'b1, 300); send(flen);
    chk(status[0] == 1'b0, "R7", "full after disabled long", int'(status[0]), 0);
    build(1'b0, 5); send(flen);
    check_frame(0, 1'b0, 1'b0, 5, "R7 recovery frame");
    chk(status[0] == 1'b1, "R7", "full after recovery", int'(status[0]), 1);

    // R7: bad short length byte
    do_cmd(2'b01, 1);
    build(1'b0, 5); fb[2] = 8'd2; send(flen);
    chk(status[0] == 1'b0, "R7", "full after length 2", int'(status[0]), 0);
    // R7: bad long length byte
    do_cmd(2'b10, 1);
    build(1'b1, 300); fb[3] = 8'd3; send(flen);
    chk(status[0] == 1'b0, "R7", "full after long length 3", int'(status[0]), 0);

    // R4: end marker early, then late
    build(1'b0, 10); send(flen - 3);
    chk(status[0] == 1'b0, "R4", "full after early end", int'(status[0]), 0);
    build(1'b0, 10); fb[flen] = 8'h5a; send(flen + 1);
    chk(status[0] == 1'b0, "R4", "full after late end", int'(status[0]), 0);
    build(1'b0, 12); send(flen);
    check_frame(1, 1'b1, 1'b0, 12, "R4 frame after mismatch");

    // R5: page sampled at frame start
    do_cmd(2'b01, 3);
    build(1'b0, 30); send(flen);
    check_frame(3, 1'b1, 1'b0, 30, "R5 new page latched");

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      logic [31:0] r;
      bit lcfg, lng;
      int pg, n;
      r = $urandom; lcfg = r[0]; lng = lcfg & r[1]; pg = int'(r[3:2]);
      n = lng ? 257 + int'(r[15:8]) % 252 : 1 + int'(r[15:8]) % 253;
      do_cmd(2'b10, int'(lcfg));
      do_cmd(2'b01, pg);
      build(lng, n); send(flen);
      check_frame(pg, lcfg, lng, n, "R1 R2 R3 random frame");
      chk(status[0] == 1'b1, "R4", "full after random frame", int'(status[0]), 1);
    end

    chk(not_ready == 0, "R10", "cycles without ready", not_ready, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule